// File: doc/BRIEF.md
# Boot Stream Block Loader

This block takes the raw byte stream that a boot source delivers, from a flash reader, a serial slave link or a parallel port, and turns it into memory writes. The stream is a chain of blocks. Each block opens with a 16-byte header. The header names a destination address and a byte count. The loader then writes each payload byte to the next address. A fill block carries no payload: the loader writes a repeating 32-bit pattern taken from the header.

Blocks follow one another until a header marked as the last one has been served. At that point the loader raises a one-cycle completion pulse, and the processor can start running from the base of instruction memory. Bytes arrive on a valid/ready handshake. A host-wait output tells a slave-mode host to hold its next byte. Each header carries a one-byte check. A corrupted header stops the loader for good, until the next reset.

Top module: `boot_block_loader`

## Requirements
- R1: After reset, in_ready is 1, host_wait is 0, and wr_en, boot_done and hdr_err are all 0.
- R2: A header is 16 bytes long and holds four little-endian 32-bit words: the control word in bytes 0 to 3, the target address in bytes 4 to 7, the byte count in bytes 8 to 11 and the fill argument in bytes 12 to 15.
- R3: Byte 0 of the header must equal the XOR of header bytes 1 to 15. On a mismatch:
  - hdr_err goes to 1 and stays there.
  - in_ready stays 0 and no write is issued, until reset.
- R4: For a block with control bit 8 clear, each accepted payload byte produces exactly one write. Writes keep the order of the stream and go to consecutive addresses that start at the target address.
- R5: For a block with control bit 8 set, no payload byte is consumed and one write is issued per cycle, count writes in all. The write at offset k from the target address carries byte (k mod 4) of the argument word, where byte 0 is the least significant.
- R6: A byte count of zero produces no writes and consumes no bytes after the header.
- R7: The loader keeps taking blocks until it has served one whose control bit 15 is set. It then pulses boot_done for one cycle:
  - The pulse comes in the same cycle as that block's last write, or, when that block has no writes, in the cycle after its header is checked.
  - After the pulse, in_ready stays 0 and no write follows.
- R8: host_wait is always the inverse of in_ready. It is 0 while header or payload bytes can be accepted. It is 1 during the header check cycle, during fill writes, after completion and after an error.
- R9: After the 16th header byte is accepted, the next cycle is a check cycle in which in_ready is 0. A write appears on the outputs in the cycle after its byte is accepted.
- R10: A cycle with in_valid at 0 consumes no byte and issues no payload write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Stream byte present |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Loader takes the byte this cycle |
| host_wait | output | 1 | Host must hold off its next byte |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | 32 | Memory write byte address |
| wr_data | output | 8 | Memory write byte |
| boot_done | output | 1 | One-cycle pulse when loading is complete |
| hdr_err | output | 1 | Sticky header check failure |

## Verification
The bench sweeps byte counts from zero to nine. It runs both copy and fill blocks, with idle gaps between bytes and unaligned target addresses. It checks every write against a list of writes built arithmetically in the bench.

Each corner case targets a specific fault:
- A fill that indexes the argument in the wrong order would write the pattern bytes in the wrong places.
- A zero count that still consumed one byte would desynchronise every later header.
- A completion pulse raised too early would come before the final write.
- A lax header check would let a corrupted header through to memory.

The bench also probes the check cycle after each header, the one-cycle write latency, and a target address that wraps at the top of the 32-bit space.

// File: rtl/boot_block_loader.sv
module boot_block_loader #(
  parameter int HDR_BYTES = 16,
  parameter int LAST_BIT  = 15,
  parameter int FILL_BIT  = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  output logic        in_ready,
  output logic        host_wait,
  output logic        wr_en,
  output logic [31:0] wr_addr,
  output logic [7:0]  wr_data,
  output logic        boot_done,
  output logic        hdr_err
);
  localparam int HW = 8 * HDR_BYTES;
  localparam int CW = $clog2(HDR_BYTES);

  typedef enum logic [2:0] {S_HDR, S_EVAL, S_LOAD, S_FILL, S_DONE, S_HALT} state_t;
  state_t state;

  logic [HW-1:0] hdr;
  logic [CW-1:0] hcnt;
  logic [7:0]    xsum;
  logic [31:0]   addr_q, left_q;
  logic [1:0]    phase;
  logic          last_q;

  wire [31:0] w_code  = hdr[31:0];
  wire [31:0] w_addr  = hdr[63:32];
  wire [31:0] w_count = hdr[95:64];
  wire [31:0] w_arg   = hdr[127:96];
  wire [7:0]  fill_b  = w_arg[8*phase +: 8];

  assign in_ready  = (state == S_HDR) || (state == S_LOAD);
  assign host_wait = ~in_ready;
  wire take = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_HDR;
      hdr       <= '0;
      hcnt      <= '0;
      xsum      <= '0;
      addr_q    <= '0;
      left_q    <= '0;
      phase     <= '0;
      last_q    <= 1'b0;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      boot_done <= 1'b0;
      hdr_err   <= 1'b0;
    end else begin
      wr_en     <= 1'b0;
      boot_done <= 1'b0;
      case (state)
        S_HDR: if (take) begin
          hdr  <= {in_data, hdr[HW-1:8]};
          xsum <= xsum ^ in_data;
          hcnt <= hcnt + 1'b1;
          if (hcnt == CW'(HDR_BYTES - 1)) state <= S_EVAL;
        end
        S_EVAL: begin
          xsum   <= '0;
          addr_q <= w_addr;
          left_q <= w_count;
          phase  <= '0;
          last_q <= w_code[LAST_BIT];
          if (xsum != 8'h00) begin
            state   <= S_HALT;
            hdr_err <= 1'b1;
          end else if (w_count == 32'd0) begin
            if (w_code[LAST_BIT]) begin
              state     <= S_DONE;
              boot_done <= 1'b1;
            end else state <= S_HDR;
          end else if (w_code[FILL_BIT]) state <= S_FILL;
          else state <= S_LOAD;
        end
        S_LOAD, S_FILL: if (take || state == S_FILL) begin
          wr_en   <= 1'b1;
          wr_addr <= addr_q;
          wr_data <= (state == S_FILL) ? fill_b : in_data;
          addr_q  <= addr_q + 32'd1;
          left_q  <= left_q - 32'd1;
          phase   <= phase + 2'd1;
          if (left_q == 32'd1) begin
            if (last_q) begin
              state     <= S_DONE;
              boot_done <= 1'b1;
            end else state <= S_HDR;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

module boot_block_loader_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_ready,
  input logic        wr_en,
  input logic [31:0] wr_addr,
  input logic        boot_done,
  input logic        hdr_err
);
  logic done_seen;
  always_ff @(posedge clk)
    if (!rst_n) done_seen <= 1'b0;
    else if (boot_done) done_seen <= 1'b1;

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |=> !boot_done);
  p_quiet_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_seen |-> (!wr_en && !in_ready));
  p_consec_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) + 32'd1));
  p_halt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_err |=> (hdr_err && !in_ready && !wr_en));
  p_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(boot_done && hdr_err));
endmodule

bind boot_block_loader boot_block_loader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .wr_en(wr_en),
  .wr_addr(wr_addr), .boot_done(boot_done), .hdr_err(hdr_err)
);

// File: tb/sim_boot_block_loader.sv
module sim_boot_block_loader;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, host_wait, wr_en, boot_done, hdr_err;
  logic [31:0] wr_addr;
  logic [7:0] wr_data;

  always #5 clk = ~clk;

  boot_block_loader u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .host_wait(host_wait), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .boot_done(boot_done), .hdr_err(hdr_err)
  );

  int checks = 0, errors = 0;
  int exp_n = 0, nwr = 0, ndone = 0;
  logic [31:0] exp_addr [0:1023];
  logic [7:0]  exp_data [0:1023];

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (wr_en) begin
      if (nwr < exp_n)
        check(wr_addr == exp_addr[nwr] && wr_data == exp_data[nwr], "R2 R4 R5 write",
              {wr_addr[23:0], wr_data}, {exp_addr[nwr][23:0], exp_data[nwr]});
      else
        check(1'b0, "R4 R6 extra write", wr_addr, 32'hFFFFFFFF);
      nwr++;
    end
    if (boot_done) begin
      ndone++;
      check(nwr == exp_n, "R7 done after last write", nwr, exp_n);
    end
  end

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0;
    repeat (3) @(negedge clk);
    exp_n = 0; nwr = 0; ndone = 0;
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b);
    in_valid = 1'b1; in_data = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [7:0] pay(input logic [31:0] a, input int k);
    return 8'((a[7:0] * 7) + k * 13 + 8'h29);
  endfunction

  task automatic send_block(input logic last, input logic fill, input logic [31:0] addr,
                            input logic [31:0] cnt, input logic [31:0] arg,
                            input int gap, input logic corrupt, input logic probe);
    logic [7:0] hb [16];
    hb[1] = {last, 6'b0, fill}; hb[2] = 8'h5A; hb[3] = 8'hC3;
    for (int i = 0; i < 4; i++) begin
      hb[4+i]  = addr[8*i +: 8];
      hb[8+i]  = cnt[8*i +: 8];
      hb[12+i] = arg[8*i +: 8];
    end
    hb[0] = corrupt ? 8'h01 : 8'h00;
    for (int i = 1; i < 16; i++) hb[0] = hb[0] ^ hb[i];
    if (!corrupt)
      for (int k = 0; k < int'(cnt); k++) begin
        exp_addr[exp_n] = addr + 32'(k);
        exp_data[exp_n] = fill ? arg[8*(k%4) +: 8] : pay(addr, k);
        exp_n++;
      end
    for (int i = 0; i < 16; i++) send(hb[i]);
    if (probe) check(!in_ready && host_wait, "R9 R8 check cycle", {in_ready, host_wait}, 2'b01);
    if (corrupt) return;
    if (!fill)
      for (int k = 0; k < int'(cnt); k++) begin
        repeat (gap) @(negedge clk);  // R10 idle cycles
        send(pay(addr, k));
        if (probe && k == 0) check(wr_en && wr_data == pay(addr, 0), "R9 write latency",
                                   {wr_en, wr_data}, {1'b1, pay(addr, 0)});
      end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hang expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    check(in_ready && !host_wait && !wr_en && !boot_done && !hdr_err, "R1 reset",
          {in_ready, host_wait, wr_en, boot_done, hdr_err}, 5'b10000);

    // Sweep of counts 0..9, copy and fill, gaps (R4 R5 R6 R10)
    for (int c = 0; c < 10; c++)
      for (int f = 0; f < 2; f++)
        send_block(c == 9 && f == 1, f[0], 32'h1000 * (2*c+f) + 32'(c*3), 32'(c),
                   32'hA1B2C3D4 ^ 32'(c), (c+f) % 3, 1'b0, 1'b0);
    repeat (20) @(negedge clk);
    check(nwr == exp_n, "R4 R5 write count", nwr, exp_n);
    check(ndone == 1, "R7 one done pulse", ndone, 1);
    check(!in_ready && host_wait && !hdr_err, "R8 R7 idle after done",
          {in_ready, host_wait, hdr_err}, 3'b010);

    // Zero-count blocks (R6)
    do_reset();
    send_block(1'b0, 1'b0, 32'h40, 32'd0, 32'd0, 0, 1'b0, 1'b0);
    send_block(1'b1, 1'b1, 32'h80, 32'd0, 32'h12345678, 0, 1'b0, 1'b0);
    repeat (5) @(negedge clk);
    check(nwr == 0, "R6 no writes", nwr, 0);
    check(ndone == 1, "R6 R7 done for empty last", ndone, 1);

    // Corrupted header (R3)
    do_reset();
    send_block(1'b0, 1'b0, 32'h200, 32'd2, 32'd0, 1, 1'b0, 1'b0);
    send_block(1'b1, 1'b0, 32'h300, 32'd4, 32'd0, 0, 1'b1, 1'b0);
    repeat (6) @(negedge clk);
    check(hdr_err && !in_ready && host_wait, "R3 halt", {hdr_err, in_ready, host_wait}, 3'b101);
    check(nwr == 2 && ndone == 0, "R3 no further writes", {nwr[15:0], ndone[15:0]}, {16'd2, 16'd0});

    // Check cycle, write latency and address wrap (R9)
    do_reset();
    send_block(1'b1, 1'b0, 32'hFFFFFFFE, 32'd3, 32'd0, 0, 1'b0, 1'b1);
    repeat (4) @(negedge clk);
    check(nwr == 3 && ndone == 1, "R9 R7 wrap block", {nwr[15:0], ndone[15:0]}, {16'd3, 16'd1});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule